// File: doc/BRIEF.md
# Wakeup interrupt polarity normaliser

This block sits in front of an interrupt controller that can only sense rising edges or active-high levels. Up to 126 raw interrupt pins enter it. Each pin has its own enable bit and its own 3-bit trigger code. Together these decide how that pin reaches its dedicated output line. Active-low levels come out inverted. Falling edges are turned into rising-edge pulses. In both-edges mode, every transition produces a rising-edge pulse. As a result, every event arrives at the controller in the one form it can sense.

Every pin passes through a two-flop synchroniser before any level or edge logic. In an edge mode the output is a pulse one clock wide. In a level mode the output tracks the synchronised, polarity-corrected input. A 32-bit register port carries software access:

- A bank of enable words sits at 0x10. Pin p is bit p%32 of the word at 0x10 + 4*(p/32).
- Each pin has its own config word at 0x110 + 4*p.

Register access is a plain strobe interface with no back-pressure. A write completes on the clock edge at which it is presented. A read may be issued on every cycle. Its data appears, with a valid flag, one cycle later.

Top module: `irq_polarity_norm`

## Requirements
- R1: After reset all enable bits and config codes are zero, every output is low and every register reads as zero.
- R2: Pin p's enable is bit p%32 of the word at byte address 0x10 + 4*(p/32). Bits with no pin behind them (bits 30 and 31 of the word at 0x1C for 126 pins) read as zero.
- R3: A write to one enable word replaces that word only. Enable bits in every other word keep their values.
- R4: Pin p's config word lives at 0x110 + 4*p. Only bits 2:0 are stored, and bits 31:3 read as zero.
- R5: Code 100 (level, active high) drives the output equal to the input, three clock edges after an input change.
- R6: Code 000 (level, active low) drives the output as the inverse of the input, with the same latency.
- R7: Code 110 (rising edge) gives exactly one single-cycle output pulse for each input rising edge, three edges after it, and none for falling edges.
- R8: Code 010 (falling edge) gives exactly one single-cycle pulse for each input falling edge, and none for rising edges.
- R9: Code 111 (both edges) gives one single-cycle pulse for each input transition in either direction.
- R10: A pin whose enable bit is clear keeps its output low, whatever its input and code.
- R11: Codes 001, 011 and 101 keep the pin's output low.
- R12: Writing a pin's config word produces no output pulse from the change of code itself. Later real edges are still reported.
- R13: Reads of unaligned or unmapped addresses return zero. Every read returns its data with rvalid high one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Raw, asynchronous interrupt inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_out | output | NUM_PINS | Normalised outputs, one per pin |

## Verification
The assertions check four rules on every cycle:
- A disabled pin or an unused code never drives its output.
- A single-edge mode never holds an output high for two cycles running.
- A write to one enable word leaves every other word's bits untouched.
- Unmapped and upper config bits read back as zero.

Only the bench's scenarios can show the rest:
- the three-edge latency and inversion of the level modes;
- that each edge mode counts the right edges and ignores the wrong ones;
- that both-edges mode reports every transition;
- that a code change itself raises no pulse.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

  typedef enum logic [1:0] {
    TM_OFF,
    TM_LEVEL,
    TM_EDGE_ONE,
    TM_EDGE_ANY
  } trig_mode_e;

  typedef struct packed {
    trig_mode_e mode;
    logic       invert;
  } trig_ctl_t;

  localparam logic [2:0] CODE_LVL_LO = 3'b000;
  localparam logic [2:0] CODE_FALL   = 3'b010;
  localparam logic [2:0] CODE_LVL_HI = 3'b100;
  localparam logic [2:0] CODE_RISE   = 3'b110;
  localparam logic [2:0] CODE_BOTH   = 3'b111;

  function automatic trig_ctl_t decode_trig(input logic [2:0] code);
    trig_ctl_t c;
    case (code)
      CODE_LVL_LO: c = '{mode: TM_LEVEL,    invert: 1'b1};
      CODE_FALL:   c = '{mode: TM_EDGE_ONE, invert: 1'b1};
      CODE_LVL_HI: c = '{mode: TM_LEVEL,    invert: 1'b0};
      CODE_RISE:   c = '{mode: TM_EDGE_ONE, invert: 1'b0};
      CODE_BOTH:   c = '{mode: TM_EDGE_ANY, invert: 1'b0};
      default:     c = '{mode: TM_OFF,      invert: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/irqn_regs.sv
module irqn_regs #(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int EN_BASE  = 'h10,
  parameter int CFG_BASE = 'h110
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  reg_rvalid,
  output logic [NUM_PINS-1:0]   en_o,
  output logic [NUM_PINS*3-1:0] cfg_o,
  output logic [NUM_PINS-1:0]   cfg_chg_o
);

  localparam int NUM_WORDS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int SEL_W     = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] EN_LO  = ADDR_W'(EN_BASE);
  localparam logic [ADDR_W-1:0] EN_HI  = ADDR_W'(EN_BASE + 4 * NUM_WORDS);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + 4 * NUM_PINS);

  logic [NUM_PINS-1:0]      en_q;
  logic [NUM_PINS-1:0][2:0] cfg_q;
  logic [NUM_PINS-1:0]      chg_q;

  logic              aligned, en_hit, cfg_hit;
  logic [ADDR_W-1:0] en_off, cfg_off;
  logic [SEL_W-1:0]  en_sel, cfg_sel;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    aligned = (reg_addr[1:0] == 2'b00);
    en_hit  = aligned && (reg_addr >= EN_LO) && (reg_addr < EN_HI);
    cfg_hit = aligned && (reg_addr >= CFG_LO) && (reg_addr < CFG_HI);
    en_off  = reg_addr - EN_LO;
    cfg_off = reg_addr - CFG_LO;
    en_sel  = en_off[ADDR_W-1:2];
    cfg_sel = cfg_off[ADDR_W-1:2];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [SEL_W-1:0] WSEL = SEL_W'(p / DATA_W);
    localparam logic [SEL_W-1:0] PSEL = SEL_W'(p);
    localparam int               BIT  = p % DATA_W;

    logic en_wr, cfg_wr;
    assign en_wr  = reg_wr && en_hit && (en_sel == WSEL);
    assign cfg_wr = reg_wr && cfg_hit && (cfg_sel == PSEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[p]  <= 1'b0;
        cfg_q[p] <= 3'b000;
        chg_q[p] <= 1'b0;
      end else begin
        if (en_wr)  en_q[p]  <= reg_wdata[BIT];
        if (cfg_wr) cfg_q[p] <= reg_wdata[2:0];
        chg_q[p] <= cfg_wr;
      end
    end

    // Enable bits of other words are untouched by this write
    assert_en_isolated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && en_hit && (en_sel == WSEL)) |=> $stable(en_q[p]));
  end

  always_comb begin
    rd_word = '0;
    if (en_hit) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (en_sel == SEL_W'(p / DATA_W)) rd_word[p % DATA_W] = en_q[p];
      end
    end else if (cfg_hit) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (cfg_sel == SEL_W'(p)) rd_word[2:0] = cfg_q[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_word : '0;
    end
  end

  assign en_o      = en_q;
  assign cfg_o     = cfg_q;
  assign cfg_chg_o = chg_q;

  assert_unmapped_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !en_hit && !cfg_hit) |=> (reg_rvalid && reg_rdata == '0));

  assert_cfg_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && cfg_hit) |=> (reg_rdata[DATA_W-1:3] == '0));

endmodule

// File: rtl/irqn_lane.sv
module irqn_lane
  import irqn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic       en,
  input  logic [2:0] cfg,
  input  logic       cfg_changed,
  output logic       irq_out
);

  logic      sync1_q, sync2_q, prev_q;
  logic      pol, out_d;
  trig_ctl_t ctl;

  assign ctl = decode_trig(cfg);
  assign pol = sync2_q ^ ctl.invert;

  always_comb begin
    case (ctl.mode)
      TM_LEVEL:    out_d = pol;
      TM_EDGE_ONE: out_d = pol & ~prev_q & ~cfg_changed;
      TM_EDGE_ANY: out_d = (pol ^ prev_q) & ~cfg_changed;
      default:     out_d = 1'b0;
    endcase
    out_d = out_d & en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      irq_out <= 1'b0;
    end else begin
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
      prev_q  <= pol;
      irq_out <= out_d;
    end
  end

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_out);

  assert_bad_code_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mode == TM_OFF) |=> !irq_out);

  // Single-edge pulses last one cycle (R7, R8)
  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && ctl.mode == TM_EDGE_ONE) |=> !irq_out);

endmodule

// File: rtl/irq_polarity_norm.sv
module irq_polarity_norm #(
  parameter int NUM_PINS = 126,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                reg_rvalid,
  output logic [NUM_PINS-1:0] irq_out
);

  logic [NUM_PINS-1:0]   en_w;
  logic [NUM_PINS*3-1:0] cfg_w;
  logic [NUM_PINS-1:0]   chg_w;

  irqn_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (32),
    .EN_BASE  ('h10),
    .CFG_BASE ('h110)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .en_o       (en_w),
    .cfg_o      (cfg_w),
    .cfg_chg_o  (chg_w)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    irqn_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_raw     (pin_in[p]),
      .en          (en_w[p]),
      .cfg         (cfg_w[p*3 +: 3]),
      .cfg_changed (chg_w[p]),
      .irq_out     (irq_out[p])
    );
  end

endmodule

// File: tb/tb_irq_polarity_norm.sv
module tb_irq_polarity_norm;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PINS   = 126;
  localparam int ADDR_W     = 12;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NUM_PINS-1:0] pins = '0;
  logic                reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0]   reg_addr = '0;
  logic [31:0]         reg_wdata = '0;
  logic [31:0]         reg_rdata;
  logic                reg_rvalid;
  logic [NUM_PINS-1:0] irq_out;

  int       total = 0, bad = 0;
  bit       done = 0;
  rd_item_t rd_q[$];
  int       pcnt[NUM_PINS];

  irq_polarity_norm #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pins),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic [ADDR_W-1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Driver: issue a read and push the expected word into the scoreboard
  task automatic rd_expect(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    it.exp = e; it.tag = tag;
    rd_q.push_back(it);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic logic [ADDR_W-1:0] cfg_addr(int p);
    return ADDR_W'('h110 + 4 * p);
  endfunction

  // Monitor: pop and compare read results
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (rd_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R13: actual=unexpected rvalid expected=none");
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(it.tag, reg_rdata, it.exp);
      end
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) if (irq_out[i]) pcnt[i]++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    for (int i = 0; i < NUM_PINS; i++) pcnt[i] = 0;
    step(4);
    rst_n = 1'b1;
    step(2);

    // R1 reset state
    chk("R1 outputs", 32'(irq_out != '0), 0);
    rd_expect('h10, 0, "R1 enable word");
    rd_expect(cfg_addr(0), 0, "R1 config word");

    // R2 / R3 enable bank
    wr_reg('h1C, 32'hFFFF_FFFF);
    rd_expect('h1C, 32'h3FFF_FFFF, "R2 top word unused bits");
    wr_reg('h10, 32'hA5A5_A5A5);
    rd_expect('h14, 0, "R3 neighbour word");
    rd_expect('h10, 32'hA5A5_A5A5, "R2 word0");
    rd_expect('h1C, 32'h3FFF_FFFF, "R3 top word kept");

    // R4 config width
    wr_reg(cfg_addr(5), 32'hFFFF_FFFC);
    rd_expect(cfg_addr(5), 32'h4, "R4 low bits only");
    for (int w = 0; w < 4; w++) wr_reg(ADDR_W'('h10 + 4 * w), 32'hFFFF_FFFF);

    // R5 level high on pin 5
    pins[5] = 1'b1;
    step(2); chk("R5 latency", irq_out[5], 0);
    step(1); chk("R5 high", irq_out[5], 1);
    pins[5] = 1'b0; step(3); chk("R5 low", irq_out[5], 0);

    // R6 level low on pin 7 (code 000)
    chk("R6 idle asserted", irq_out[7], 1);
    pins[7] = 1'b1; step(3); chk("R6 inverted", irq_out[7], 0);
    pins[7] = 1'b0; step(3); chk("R6 back", irq_out[7], 1);

    // R7 rising edge on pin 10
    wr_reg(cfg_addr(10), 32'h6); step(2);
    base = pcnt[10];
    pins[10] = 1'b1; step(3); chk("R7 pulse", irq_out[10], 1);
    step(1); chk("R7 pulse width", irq_out[10], 0);
    pins[10] = 1'b0; step(5);
    chk("R7 one pulse per rise", pcnt[10] - base, 1);

    // R8 falling edge on pin 11
    wr_reg(cfg_addr(11), 32'h2); step(2);
    base = pcnt[11];
    pins[11] = 1'b1; step(5);
    chk("R8 rise ignored", pcnt[11] - base, 0);
    pins[11] = 1'b0; step(3); chk("R8 pulse", irq_out[11], 1);
    step(3); chk("R8 count", pcnt[11] - base, 1);

    // R9 both edges on pin 12
    wr_reg(cfg_addr(12), 32'h7); step(2);
    base = pcnt[12];
    pins[12] = 1'b1; step(5);
    pins[12] = 1'b0; step(5);
    pins[12] = 1'b1; step(5);
    chk("R9 every transition", pcnt[12] - base, 3);

    // R10 disabled pins: 13 edge mode, 7 level-low
    wr_reg(cfg_addr(13), 32'h6);
    wr_reg('h10, 32'hFFFF_DF7F); step(2);
    chk("R10 level pin off", irq_out[7], 0);
    base = pcnt[13];
    pins[13] = 1'b1; step(5); pins[13] = 1'b0; step(5);
    chk("R10 edge pin quiet", pcnt[13] - base, 0);

    // R11 unused codes
    wr_reg(cfg_addr(20), 32'h1);
    wr_reg(cfg_addr(21), 32'h3);
    wr_reg(cfg_addr(22), 32'h5); step(2);
    base = pcnt[20] + pcnt[21] + pcnt[22];
    pins[22:20] = 3'b111; step(5);
    chk("R11 high input", 32'(irq_out[22:20]), 0);
    pins[22:20] = 3'b000; step(5);
    chk("R11 no activity", pcnt[20] + pcnt[21] + pcnt[22] - base, 0);

    // R12 code change is not an edge: pin 30 low, rising -> falling
    wr_reg(cfg_addr(30), 32'h6); step(4);
    base = pcnt[30];
    wr_reg(cfg_addr(30), 32'h2); step(4);
    chk("R12 no spurious pulse", pcnt[30] - base, 0);
    pins[30] = 1'b1; step(5); pins[30] = 1'b0; step(5);
    chk("R12 real edge kept", pcnt[30] - base, 1);

    // R13 unmapped and unaligned reads
    rd_expect('h000, 0, "R13 addr 0x000");
    rd_expect('h020, 0, "R13 addr 0x020");
    rd_expect('h10C, 0, "R13 addr 0x10C");
    rd_expect('h308, 0, "R13 addr 0x308");
    rd_expect('h112, 0, "R13 unaligned");
    step(3);
    chk("R13 all reads returned", rd_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule